// File: doc/BRIEF.md
# Blocking-Read Shared Message Mailbox

A hardware message queue that sits on a memory-mapped bus between several producing processors and one consuming processor. Producers push 32-bit messages through a write-side slave port; the owning processor pulls them out, oldest first, through a read-side slave port. Each message moves in one indivisible bus access, so messages from different producers never interleave within a word.

The consumer never sees an underflow. A data read on an empty queue is held with `rd_waitrequest` until a message exists, and then completes. When a producer writes while the consumer is held on an empty queue, the message goes straight to the consumer without touching the storage. A producer that writes into a full queue is likewise held with `wr_waitrequest` until a slot frees, so nothing is dropped. A status word gives the fill level, an empty flag and a full flag, and reading it never stalls. This makes the block a building element for barriers and work hand-off between processors.

Top module: `shared_mailbox`

## Requirements
- R1: While `rst` is high at a rising clock edge the queue is emptied; the first status read after reset returns count 0 with the empty flag set and the full flag clear.
- R2: Messages come out of the data offset (address 0) in the exact order they were accepted, with all 32 bits intact; `rd_readdata` holds the result in the cycle after the rising edge at which the read was accepted (`rd_read` high, `rd_waitrequest` low).
- R3: A data read while the queue is empty and no data write is presented in that cycle keeps `rd_waitrequest` high, for as many cycles as that lasts, and changes no queue state.
- R4: When a data write is presented in a cycle where a data read is held on an empty queue, both are accepted in that cycle, the read returns the written word one cycle later, and the count stays 0.
- R5: A data write while the queue holds DEPTH messages keeps `wr_waitrequest` high; it is accepted in the cycle after a read frees a slot, and its message follows all earlier ones.
- R6: A read at any nonzero address (status) never stalls and returns the count in bits [15:0] (bits [9:0] suffice for 512 entries), the empty flag in bit 16, the full flag in bit 17, and zero in all other bits.
- R7: A data read and a data write accepted in the same cycle on a queue that is neither empty nor full both take effect and leave the count unchanged.
- R8: A write at a nonzero address is accepted without stall and has no effect on the queue contents or count.
- R9: While `rst` is high both `wr_waitrequest` and `rd_waitrequest` are high; after reset a held data write is accepted and a held data read keeps waiting on the now empty queue.
- R10: The queue holds exactly DEPTH messages: after DEPTH accepted writes with no reads the full flag is set and the count equals DEPTH.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_write | input | 1 | Producer write request |
| wr_address | input | ADDR_W | Producer offset: 0 data, nonzero ignored |
| wr_writedata | input | DATA_W | Message to enqueue |
| wr_waitrequest | output | 1 | Producer access not yet accepted |
| rd_read | input | 1 | Consumer read request |
| rd_address | input | ADDR_W | Consumer offset: 0 data, nonzero status |
| rd_readdata | output | DATA_W | Message or status word, one cycle after acceptance |
| rd_waitrequest | output | 1 | Consumer access not yet accepted |

## Verification
The bench builds the mailbox with DEPTH set to 4, a non-default but power-of-two depth that keeps the data width at 32, so the full boundary is reached within a few writes. With that depth every fill level from 0 to full is swept, each level drained and compared word for word against arithmetically generated patterns, and the status word checked at each level. The small depth also puts the stalled-write-then-release sequence, the empty-queue bypass and the reset-while-loaded case within a handful of cycles, so their exact stall counts can be predicted and checked.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   // Status word layout, read at any nonzero consumer offset.
   localparam int unsigned STAT_EMPTY_BIT = 16;
   localparam int unsigned STAT_FULL_BIT  = 17;
   localparam int unsigned STAT_CNT_MAX_W = 16;

   // Source of the consumer read data in the cycle after acceptance.
   typedef enum logic {
      RD_SRC_RAM  = 1'b0,
      RD_SRC_SIDE = 1'b1
   } rd_src_e;
endpackage

// File: rtl/mbx_ram.sv
module mbx_ram #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 512,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
      if (re) rdata <= store[raddr];
   end
endmodule

// File: rtl/mbx_ptr.sv
module mbx_ptr #(
   parameter int unsigned DEPTH = 512,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam bit POW2          = ((DEPTH & (DEPTH - 1)) == 0)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   output logic [AW-1:0] ptr
);
   generate
      if (POW2) begin : g_pow2
         always_ff @(posedge clk) begin
            if (rst)      ptr <= '0;
            else if (adv) ptr <= ptr + 1'b1;
         end
      end else begin : g_wrap
         localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
         always_ff @(posedge clk) begin
            if (rst)      ptr <= '0;
            else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl #(
   parameter int unsigned DEPTH  = 512,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_req,
   input  logic             rd_req,
   output logic             wr_acc,
   output logic             rd_acc,
   output logic             bypass,
   output logic             ram_we,
   output logic             ram_re,
   output logic [AW-1:0]    wptr,
   output logic [AW-1:0]    rptr,
   output logic [CNT_W-1:0] cnt,
   output logic             empty,
   output logic             full
);
   assign empty  = (cnt == '0);
   assign full   = (cnt == CNT_W'(DEPTH));

   // Writes only wait on a full queue; reads on an empty one unless a write
   // arrives in the same cycle, which is then handed straight across.
   assign wr_acc = wr_req && !full && !rst;
   assign rd_acc = rd_req && !rst && (!empty || wr_acc);
   assign bypass = rd_acc && empty;
   assign ram_we = wr_acc && !bypass;
   assign ram_re = rd_acc && !bypass;

   mbx_ptr #(.DEPTH(DEPTH)) u_wptr (.clk(clk), .rst(rst), .adv(ram_we), .ptr(wptr));
   mbx_ptr #(.DEPTH(DEPTH)) u_rptr (.clk(clk), .rst(rst), .adv(ram_re), .ptr(rptr));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else begin
         case ({ram_we, ram_re})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/shared_mailbox.sv
module shared_mailbox #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 512,
   parameter int unsigned ADDR_W = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_write,
   input  logic [ADDR_W-1:0] wr_address,
   input  logic [DATA_W-1:0] wr_writedata,
   output logic              wr_waitrequest,
   input  logic              rd_read,
   input  logic [ADDR_W-1:0] rd_address,
   output logic [DATA_W-1:0] rd_readdata,
   output logic              rd_waitrequest
);
   import mbx_pkg::*;

   localparam int unsigned AW    = $clog2(DEPTH);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("shared_mailbox: DEPTH must be at least 2");
      end
      if (CNT_W > STAT_CNT_MAX_W) begin : g_bad_cnt
         $error("shared_mailbox: count does not fit the status field");
      end
      if (DATA_W <= STAT_FULL_BIT) begin : g_bad_width
         $error("shared_mailbox: DATA_W too narrow for the status word");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("shared_mailbox: ADDR_W must be at least 1");
      end
   endgenerate

   logic              wr_data_req, rd_data_req, rd_stat_req;
   logic              wr_acc, rd_acc, bypass, ram_we, ram_re;
   logic              empty, full;
   logic [AW-1:0]     wptr, rptr;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] ram_q, side_q, stat_word;
   rd_src_e           src_q;

   assign wr_data_req = wr_write && (wr_address == '0);
   assign rd_data_req = rd_read  && (rd_address == '0);
   assign rd_stat_req = rd_read  && (rd_address != '0) && !rst;

   mbx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst(rst),
      .wr_req(wr_data_req), .rd_req(rd_data_req),
      .wr_acc(wr_acc), .rd_acc(rd_acc), .bypass(bypass),
      .ram_we(ram_we), .ram_re(ram_re),
      .wptr(wptr), .rptr(rptr),
      .cnt(cnt), .empty(empty), .full(full)
   );

   mbx_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
      .clk(clk),
      .we(ram_we), .waddr(wptr), .wdata(wr_writedata),
      .re(ram_re), .raddr(rptr), .rdata(ram_q)
   );

   always_comb begin
      stat_word                 = '0;
      stat_word[CNT_W-1:0]      = cnt;
      stat_word[STAT_EMPTY_BIT] = empty;
      stat_word[STAT_FULL_BIT]  = full;
   end

   // Side register carries the status word or a bypassed message.
   always_ff @(posedge clk) begin
      if (rst) begin
         src_q  <= RD_SRC_SIDE;
         side_q <= '0;
      end else if (bypass) begin
         src_q  <= RD_SRC_SIDE;
         side_q <= wr_writedata;
      end else if (rd_stat_req) begin
         src_q  <= RD_SRC_SIDE;
         side_q <= stat_word;
      end else if (ram_re) begin
         src_q  <= RD_SRC_RAM;
      end
   end

   assign rd_readdata    = (src_q == RD_SRC_RAM) ? ram_q : side_q;
   assign wr_waitrequest = rst || (wr_data_req && !wr_acc);
   assign rd_waitrequest = rst || (rd_data_req && !rd_acc);
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
   parameter int unsigned DEPTH  = 512,
   parameter int unsigned ADDR_W = 1,
   parameter int unsigned CNT_W  = 10
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_write,
   input logic [ADDR_W-1:0] wr_address,
   input logic              wr_waitrequest,
   input logic              rd_read,
   input logic [ADDR_W-1:0] rd_address,
   input logic              rd_waitrequest,
   input logic [CNT_W-1:0]  cnt
);
   logic wr_dreq, rd_dreq, wr_dacc, rd_dacc;
   assign wr_dreq = wr_write && (wr_address == '0);
   assign rd_dreq = rd_read  && (rd_address == '0);
   assign wr_dacc = wr_dreq && !wr_waitrequest;
   assign rd_dacc = rd_dreq && !rd_waitrequest;

   // R1
   a_r1_reset_empties: assert property (@(posedge clk)
      $past(rst) |-> (cnt == '0));

   // R3
   a_r3_empty_read_waits: assert property (@(posedge clk) disable iff (rst)
      (rd_dreq && cnt == '0 && !wr_dreq) |-> rd_waitrequest);

   // R4
   a_r4_bypass_no_wait: assert property (@(posedge clk) disable iff (rst)
      (rd_dreq && wr_dreq && cnt == '0) |-> (!rd_waitrequest && !wr_waitrequest));

   // R5
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
      int'(cnt) <= int'(DEPTH));

   a_r5_full_write_waits: assert property (@(posedge clk) disable iff (rst)
      (wr_dreq && int'(cnt) == int'(DEPTH)) |-> wr_waitrequest);

   // R6
   a_r6_status_no_wait: assert property (@(posedge clk) disable iff (rst)
      (rd_read && rd_address != '0) |-> !rd_waitrequest);

   // R7
   a_r7_count_tracks_accepts: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (int'(cnt) == int'($past(cnt)) + int'($past(wr_dacc)) - int'($past(rd_dacc))));

   // R9
   a_r9_reset_holds_ports: assert property (@(posedge clk)
      rst |-> (wr_waitrequest && rd_waitrequest));
endmodule

bind shared_mailbox mbx_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_mbx_checker (
   .clk(clk), .rst(rst),
   .wr_write(wr_write), .wr_address(wr_address), .wr_waitrequest(wr_waitrequest),
   .rd_read(rd_read), .rd_address(rd_address), .rd_waitrequest(rd_waitrequest),
   .cnt(cnt)
);

// File: tb/shared_mailbox_bench.sv
module shared_mailbox_bench;
   localparam int DW = 32;
   localparam int D  = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_write = 1'b0;
   logic [0:0]    wr_address = '0;
   logic [DW-1:0] wr_writedata = '0;
   logic          wr_waitrequest;
   logic          rd_read = 1'b0;
   logic [0:0]    rd_address = '0;
   logic [DW-1:0] rd_readdata;
   logic          rd_waitrequest;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   shared_mailbox #(.DATA_W(DW), .DEPTH(D), .ADDR_W(1)) u_shared_mailbox (
      .clk(clk), .rst(rst),
      .wr_write(wr_write), .wr_address(wr_address), .wr_writedata(wr_writedata),
      .wr_waitrequest(wr_waitrequest),
      .rd_read(rd_read), .rd_address(rd_address), .rd_readdata(rd_readdata),
      .rd_waitrequest(rd_waitrequest)
   );

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] stat_exp(input int n);
      logic [DW-1:0] s = '0;
      s[15:0] = 16'(n);
      s[16]   = (n == 0);
      s[17]   = (n == D);
      return s;
   endfunction

   function automatic logic [DW-1:0] pat(input int a, input int b);
      return (32'(a) * 32'h0101_0000) ^ (32'(b) * 32'h0000_1111) ^ 32'hC35A_0000;
   endfunction

   task automatic do_write(input logic a, input logic [DW-1:0] d, output int stalls);
      @(negedge clk);
      wr_write = 1'b1; wr_address = a; wr_writedata = d; stalls = 0;
      forever begin
         #7;
         if (!wr_waitrequest) break;
         stalls++;
         @(negedge clk);
      end
      @(negedge clk);
      wr_write = 1'b0;
   endtask

   task automatic do_read(input logic a, output logic [DW-1:0] d, output int stalls);
      @(negedge clk);
      rd_read = 1'b1; rd_address = a; stalls = 0;
      forever begin
         #7;
         if (!rd_waitrequest) break;
         stalls++;
         @(negedge clk);
      end
      @(negedge clk);
      rd_read = 1'b0;
      d = rd_readdata;
   endtask

   task automatic status_is(input int n, input string req);
      logic [DW-1:0] s;
      int st;
      do_read(1'b1, s, st);
      chk(st == 0, {req, " status stall"}, DW'(st), '0);
      chk(s == stat_exp(n), {req, " status word"}, s, stat_exp(n));
   endtask

   initial begin
      logic [DW-1:0] got;
      int st, st2;

      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1 / R6: state after reset
      status_is(0, "R1");

      // R2 / R6 / R10: sweep every fill level, drain in order
      for (int n = 1; n <= D; n++) begin
         for (int i = 0; i < n; i++) begin
            do_write(1'b0, pat(n, i), st);
            chk(st == 0, "R10 write below capacity stalled", DW'(st), '0);
         end
         status_is(n, "R6");
         for (int i = 0; i < n; i++) begin
            do_read(1'b0, got, st);
            chk(st == 0, "R2 nonempty read stalled", DW'(st), '0);
            chk(got == pat(n, i), "R2 order/data", got, pat(n, i));
         end
         status_is(0, "R2");
      end

      // R3 / R4: read held on empty queue, then a write meets it
      fork
         begin
            do_read(1'b0, got, st);
         end
         begin
            repeat (3) @(negedge clk);
            do_write(1'b0, 32'hFEED_0001, st2);
         end
      join
      chk(st == 3, "R3 empty read stall cycles", DW'(st), 32'd3);
      chk(got == 32'hFEED_0001, "R4 bypass data", got, 32'hFEED_0001);
      chk(st2 == 0, "R4 bypass write stall", DW'(st2), '0);
      status_is(0, "R4");

      // R5: write into full queue waits until a read frees a slot
      for (int i = 0; i < D; i++) do_write(1'b0, pat(9, i), st);
      status_is(D, "R10");
      // R8: write to status offset ignored, even when full
      do_write(1'b1, 32'hDEAD_BEEF, st);
      chk(st == 0, "R8 status write stall", DW'(st), '0);
      status_is(D, "R8");
      fork
         begin
            do_write(1'b0, pat(9, D), st2);
         end
         begin
            repeat (2) @(negedge clk);
            do_read(1'b0, got, st);
         end
      join
      chk(st2 == 3, "R5 full write stall cycles", DW'(st2), 32'd3);
      chk(got == pat(9, 0), "R5 oldest first", got, pat(9, 0));
      for (int i = 1; i <= D; i++) begin
         do_read(1'b0, got, st);
         chk(got == pat(9, i), "R5 order after release", got, pat(9, i));
      end
      status_is(0, "R5");

      // R7: simultaneous read and write on a partly filled queue
      do_write(1'b0, 32'hAAAA_0001, st);
      do_write(1'b0, 32'hAAAA_0002, st);
      fork
         begin do_read(1'b0, got, st); end
         begin do_write(1'b0, 32'hAAAA_0003, st2); end
      join
      chk(got == 32'hAAAA_0001, "R7 read data", got, 32'hAAAA_0001);
      chk(st == 0 && st2 == 0, "R7 no stall", DW'(st + st2), '0);
      status_is(2, "R7");
      do_read(1'b0, got, st);
      chk(got == 32'hAAAA_0002, "R7 second", got, 32'hAAAA_0002);
      do_read(1'b0, got, st);
      chk(got == 32'hAAAA_0003, "R7 third", got, 32'hAAAA_0003);

      // R9: reset while loaded and while accesses are presented
      do_write(1'b0, 32'h1234_5678, st);
      do_write(1'b0, 32'h8765_4321, st);
      @(negedge clk);
      rst = 1'b1; rd_read = 1'b1; rd_address = 1'b0;
      wr_write = 1'b1; wr_address = 1'b0; wr_writedata = 32'h0BAD_F00D;
      #7;
      chk(rd_waitrequest == 1'b1, "R9 read held in reset", DW'(rd_waitrequest), 32'd1);
      chk(wr_waitrequest == 1'b1, "R9 write held in reset", DW'(wr_waitrequest), 32'd1);
      @(negedge clk);
      rd_read = 1'b0; wr_write = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      status_is(0, "R1 reset while loaded");
      // R9: after reset a data read waits on the empty queue
      @(negedge clk);
      rd_read = 1'b1; rd_address = 1'b0;
      #7;
      chk(rd_waitrequest == 1'b1, "R9 read waits after reset", DW'(rd_waitrequest), 32'd1);
      @(negedge clk);
      rd_read = 1'b0;
      do_write(1'b0, 32'h5555_AAAA, st);
      chk(st == 0, "R9 write accepted after reset", DW'(st), '0);
      do_read(1'b0, got, st);
      chk(got == 32'h5555_AAAA, "R9 data after reset", got, 32'h5555_AAAA);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule